// File: doc/BRIEF.md
# Operand Address and Branch Target Calculator

This unit sits beside the fetch path of an 8-bit processor core that has a 16-bit address space. When the core has accepted an opcode, it presents a start pulse with a mode code, the current index register value, the address the opcode was fetched from and the branch condition. The unit then takes the operand bytes that follow the opcode, one byte per clock, from a byte stream. After the last byte of the instruction it raises a one-cycle completion strobe. While the strobe is high, it reports the operand effective address (or the branch target), the instruction length and the address execution continues from.

Five ways of forming an address are supported:
- a full 16-bit address carried in the instruction;
- the index register alone, which reaches the first page only;
- the index register plus one unsigned byte, with the carry kept;
- the index register plus a 16-bit offset, which wraps around the top of memory;
- a signed byte displacement for branches, taken from the address after the branch.

The index is always treated as unsigned and zero-extended. Opcode decoding, memory access and execution are left to the rest of the core.

Top module: `opaddr_unit`

## Requirements
- R1: While reset is asserted and just after its release, `done` is low and `ea` reads 0x0000.
- R2: Mode code 0 (absolute) takes two operand bytes, high byte first; `ea` is the two bytes joined as {first, second}, and `ilen` is 3.
- R3: Mode code 1 (index only) takes no operand bytes; `ea` is {0x00, index}, `ilen` is 1, and `done` rises in the cycle after the start is accepted.
- R4: Mode code 2 (index plus byte) takes one operand byte; `ea` is the 9-bit unsigned sum of index and byte, zero-extended, so 0xFF + 0xFF gives 0x01FE; `ilen` is 2.
- R5: Mode code 3 (index plus 16-bit offset) takes two bytes, high first; `ea` is (offset + index) modulo 65536, and `ilen` is 3.
- R6: Mode code 4 (branch) takes one byte, read as signed two's complement; `ea` is (opcode address + 2 + displacement) modulo 65536, so 0x80 gives −128 and 0x7F gives +127; `ilen` is 2.
- R7: `next_pc` equals `ea` for a branch whose condition was 1 at start; in every other case it equals the opcode address plus `ilen`, and the displacement has no effect on it.
- R8: `done` is high for exactly one cycle, in the cycle after the last operand byte is accepted; cycles in which `byte_vld` is low are skipped and do not count as bytes.
- R9: `start` is ignored while operand bytes are outstanding or while `done` is high, and `byte_vld` is ignored while the unit is idle.
- R10: Mode, index, opcode address and condition are sampled when the start is accepted; later changes on those inputs do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opcode accepted; sample mode and context |
| mode | input | 3 | Addressing mode code (0..4) |
| idx | input | 8 | Index register value |
| pc | input | 16 | Address of the opcode |
| cond | input | 1 | Branch condition |
| byte_vld | input | 1 | Operand byte present on `byte_in` |
| byte_in | input | 8 | Operand byte |
| ea | output | 16 | Effective address or branch target |
| ilen | output | 2 | Instruction length in bytes |
| next_pc | output | 16 | Address of the next instruction to run |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest conditions to reach from the ports are the collisions: a start request that arrives while bytes are still outstanding, a start in the very cycle `done` is high, and stray bytes while the unit is idle. In each of these cases, only the absence of a wrong pulse shows the correct behaviour. The directed tasks place these requests on exact negative edges relative to the byte stream. They then confirm that `done` stays low in the cycle where a wrongly accepted request would have pulsed it, and that the result still reflects the original instruction. Gapped byte delivery and context inputs changed right after start are used in the same way, to show that only accepted bytes count and that only the sampled context is used.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  typedef enum logic [2:0] {
    AM_ABS   = 3'd0,
    AM_IDX0  = 3'd1,
    AM_IDX8  = 3'd2,
    AM_IDX16 = 3'd3,
    AM_BRA   = 3'd4
  } amode_e;

  // number of operand bytes that follow the opcode
  function automatic logic [1:0] operand_bytes(input logic [2:0] m);
    case (m)
      AM_ABS, AM_IDX16: operand_bytes = 2'd2;
      AM_IDX8, AM_BRA:  operand_bytes = 2'd1;
      default:          operand_bytes = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/opaddr_seq.sv
module opaddr_seq #(
  parameter int MAX_OPB = 2,
  localparam int CW = $clog2(MAX_OPB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] need,
  input  logic          byte_vld,
  output logic          start_acc,
  output logic          take,
  output logic          busy,
  output logic          done
);

  logic [CW-1:0] rem_q, rem_d;
  logic          done_q, done_d;

  assign busy      = (rem_q != '0);
  assign start_acc = start & ~busy & ~done_q;
  assign take      = busy & byte_vld;
  assign done      = done_q;

  always_comb begin
    rem_d  = rem_q;
    done_d = 1'b0;
    if (start_acc) begin
      if (need == '0) done_d = 1'b1;
      else            rem_d  = need;
    end else if (take) begin
      rem_d = rem_q - CW'(1);
      if (rem_q == CW'(1)) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      done_q <= done_d;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(take || start_acc)); // R8

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($past(rem_q) == rem_q) || ($past(take))); // R9

endmodule

// File: rtl/opaddr_calc.sv
module opaddr_calc
  import opaddr_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [2:0]    mode,
  input  logic [DW-1:0] idx,
  input  logic [AW-1:0] pc,
  input  logic          cond,
  input  logic [DW-1:0] ob_hi,
  input  logic [DW-1:0] ob_lo,
  output logic [AW-1:0] ea,
  output logic [1:0]    ilen,
  output logic [AW-1:0] next_pc
);

  logic [AW-1:0] idx_z, lo_z, lo_s, off_w, seq_pc;

  assign idx_z = {{(AW-DW){1'b0}}, idx};
  assign lo_z  = {{(AW-DW){1'b0}}, ob_lo};
  assign lo_s  = {{(AW-DW){ob_lo[DW-1]}}, ob_lo};
  assign off_w = {ob_hi, ob_lo};

  always_comb begin
    case (mode)
      AM_ABS: begin
        ea   = off_w;
        ilen = 2'd3;
      end
      AM_IDX8: begin
        ea   = idx_z + lo_z;
        ilen = 2'd2;
      end
      AM_IDX16: begin
        ea   = off_w + idx_z;
        ilen = 2'd3;
      end
      AM_BRA: begin
        ea   = pc + AW'(2) + lo_s;
        ilen = 2'd2;
      end
      default: begin
        ea   = idx_z;
        ilen = 2'd1;
      end
    endcase
  end

  assign seq_pc  = pc + {{(AW-2){1'b0}}, ilen};
  assign next_pc = (mode == AM_BRA && cond) ? ea : seq_pc;

endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
  import opaddr_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] idx,
  input  logic [AW-1:0] pc,
  input  logic          cond,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_in,
  output logic [AW-1:0] ea,
  output logic [1:0]    ilen,
  output logic [AW-1:0] next_pc,
  output logic          done
);

  localparam logic [AW-1:0] IDX8_TOP = AW'(2 * ((1 << DW) - 1));
  localparam logic [AW-1:0] FWD_MAX  = AW'((1 << (DW - 1)) - 1);
  localparam logic [AW-1:0] BACK_MIN = AW'((1 << AW) - (1 << (DW - 1)));

  logic          start_acc, take, busy;
  logic [2:0]    mode_q;
  logic [DW-1:0] idx_q, ob_hi_q, ob_lo_q;
  logic [AW-1:0] pc_q;
  logic          cond_q;
  logic [AW-1:0] br_gap;

  opaddr_seq #(.MAX_OPB(2)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .need      (operand_bytes(mode)),
    .byte_vld  (byte_vld),
    .start_acc (start_acc),
    .take      (take),
    .busy      (busy),
    .done      (done)
  );

  // context sampled with the accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AM_ABS;
      idx_q  <= '0;
      pc_q   <= '0;
      cond_q <= 1'b0;
    end else if (start_acc) begin
      mode_q <= mode;
      idx_q  <= idx;
      pc_q   <= pc;
      cond_q <= cond;
    end
  end

  // operand bytes shift in: first byte ends in ob_hi for two-byte forms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_hi_q <= '0;
      ob_lo_q <= '0;
    end else if (take) begin
      ob_hi_q <= ob_lo_q;
      ob_lo_q <= byte_in;
    end
  end

  opaddr_calc #(.DW(DW)) calc_i (
    .mode    (mode_q),
    .idx     (idx_q),
    .pc      (pc_q),
    .cond    (cond_q),
    .ob_hi   (ob_hi_q),
    .ob_lo   (ob_lo_q),
    .ea      (ea),
    .ilen    (ilen),
    .next_pc (next_pc)
  );

  assign br_gap = ea - pc_q - AW'(2);

  AST_IDX0_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == AM_IDX0) |-> (ea[AW-1:DW] == '0)); // R3

  AST_IDX8_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == AM_IDX8) |-> (ea <= IDX8_TOP)); // R4

  AST_BRA_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == AM_BRA) |-> (br_gap <= FWD_MAX || br_gap >= BACK_MIN)); // R6

  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(mode_q == AM_BRA && cond_q)) |-> (next_pc - pc_q == {{(AW-2){1'b0}}, ilen})); // R7

  AST_CTX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_acc) |=> $stable(mode_q) && $stable(pc_q)); // R10

endmodule

// File: tb/opaddr_unit_tb.sv
module opaddr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, cond, byte_vld;
  logic [2:0]  mode;
  logic [7:0]  idx, byte_in;
  logic [15:0] pc;
  logic [15:0] ea, next_pc;
  logic [1:0]  ilen;
  logic        done;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  opaddr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx(idx),
    .pc(pc), .cond(cond), .byte_vld(byte_vld), .byte_in(byte_in),
    .ea(ea), .ilen(ilen), .next_pc(next_pc), .done(done)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic int nbytes(input int m);
    if (m == 0 || m == 3) return 2;
    if (m == 2 || m == 4) return 1;
    return 0;
  endfunction

  // independent reference model
  task automatic model(input int m, input int ix, input int p, input int c,
                       input int b0, input int b1,
                       output int e, output int l, output int np);
    int d;
    case (m)
      0: begin e = b0 * 256 + b1; l = 3; end
      2: begin e = ix + b0; l = 2; end
      3: begin e = (b0 * 256 + b1 + ix) % 65536; l = 3; end
      4: begin
        d = (b0 >= 128) ? b0 - 256 : b0;
        e = (p + 2 + d + 65536) % 65536; l = 2;
      end
      default: begin e = ix; l = 1; end
    endcase
    np = (m == 4 && c != 0) ? e : (p + l) % 65536;
  endtask

  task automatic idle_inputs();
    start = 0; byte_vld = 0; byte_in = 8'h00;
  endtask

  // issue one instruction; returns at the negedge where done is expected
  task automatic issue(input string rq, input int m, input int ix, input int p,
                       input int c, input int b0, input int b1, input bit gap);
    int n = nbytes(m);
    @(negedge clk);
    start = 1; mode = 3'(m); idx = 8'(ix); pc = 16'(p); cond = c[0];
    @(negedge clk);
    start = 0;
    // scramble context after sampling (R10)
    mode = 3'(~m); idx = ~idx; pc = ~pc; cond = ~cond;
    for (int i = 0; i < n; i++) begin
      if (gap) begin
        byte_vld = 0; byte_in = 8'hA5;
        @(negedge clk);
        chk("R8", "done during gap", int'(done), 0);
      end
      chk("R8", "done before last byte", int'(done), 0);
      byte_vld = 1; byte_in = 8'((i == 0) ? b0 : b1);
      @(negedge clk);
      byte_vld = 0;
    end
  endtask

  task automatic expect_result(input string rq, input int m, input int ix, input int p,
                               input int c, input int b0, input int b1);
    int e, l, np;
    model(m, ix, p, c, b0, b1, e, l, np);
    chk(rq, "done", int'(done), 1);
    chk(rq, "ea", int'(ea), e);
    chk(rq, "ilen", int'(ilen), l);
    chk("R7", "next_pc", int'(next_pc), np);
    @(negedge clk);
    chk("R8", "done width", int'(done), 0);
  endtask

  task automatic run(input string rq, input int m, input int ix, input int p,
                     input int c, input int b0, input int b1, input bit gap);
    issue(rq, m, ix, p, c, b0, b1, gap);
    expect_result(rq, m, ix, p, c, b0, b1);
  endtask

  task automatic t_reset();
    idle_inputs(); mode = 0; idx = 0; pc = 0; cond = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "ea in reset", int'(ea), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "ea after reset", int'(ea), 0);
  endtask

  task automatic t_abs();
    run("R2", 0, 8'h44, 16'h1000, 0, 8'h12, 8'h34, 0);
    run("R2", 0, 8'hFF, 16'hFFFD, 1, 8'hFF, 8'hFF, 0);
  endtask

  task automatic t_idx0();
    run("R3", 1, 8'h00, 16'h0200, 0, 0, 0, 0);
    run("R3", 1, 8'hFF, 16'hFFFF, 1, 0, 0, 0);
  endtask

  task automatic t_idx8();
    run("R4", 2, 8'hFF, 16'h0300, 0, 8'hFF, 0, 0);
    run("R4", 2, 8'h10, 16'h0310, 0, 8'hF8, 0, 0);
    run("R4", 2, 8'h00, 16'h0320, 0, 8'h00, 0, 0);
  endtask

  task automatic t_idx16();
    run("R5", 3, 8'h20, 16'h0400, 0, 8'hFF, 8'hF0, 0);
    run("R5", 3, 8'hFF, 16'h0410, 0, 8'hFF, 8'hFF, 0);
    run("R5", 3, 8'h05, 16'h0420, 0, 8'h12, 8'h00, 0);
  endtask

  task automatic t_branch();
    run("R6", 4, 8'h00, 16'h0500, 1, 8'h80, 0, 0);
    run("R6", 4, 8'h00, 16'h0500, 1, 8'h7F, 0, 0);
    run("R6", 4, 8'h00, 16'h0000, 1, 8'h80, 0, 0);
    run("R6", 4, 8'h00, 16'hFFF0, 1, 8'h7F, 0, 0);
    run("R7", 4, 8'h00, 16'h0600, 0, 8'h80, 0, 0);
    run("R7", 4, 8'h00, 16'h0600, 0, 8'h7F, 0, 0);
  endtask

  task automatic t_gaps();
    run("R8", 3, 8'h03, 16'h0700, 0, 8'h0A, 8'hBC, 1);
    run("R8", 4, 8'h00, 16'h0800, 1, 8'hFE, 0, 1);
  endtask

  task automatic t_collide();
    // stray bytes while idle must not count
    @(negedge clk);
    byte_vld = 1; byte_in = 8'h33;
    @(negedge clk);
    chk("R9", "stray byte done", int'(done), 0);
    @(negedge clk);
    chk("R9", "stray byte done", int'(done), 0);
    byte_vld = 0;
    run("R9", 2, 8'h01, 16'h0900, 0, 8'h10, 0, 0);

    // start while bytes are outstanding
    @(negedge clk);
    start = 1; mode = 0; idx = 0; pc = 16'h0A00; cond = 0;
    @(negedge clk);
    start = 0; byte_vld = 1; byte_in = 8'hC0;
    @(negedge clk);
    byte_vld = 0; start = 1; mode = 1; idx = 8'h55;
    @(negedge clk);
    start = 0;
    chk("R9", "start mid-collect", int'(done), 0);
    byte_vld = 1; byte_in = 8'hDE;
    @(negedge clk);
    byte_vld = 0;
    chk("R9", "done mid-collect", int'(done), 1);
    chk("R9", "ea mid-collect", int'(ea), 16'hC0DE);
    // start during the done cycle
    start = 1; mode = 1; idx = 8'h66;
    @(negedge clk);
    start = 0;
    chk("R9", "start on done", int'(done), 0);
    chk("R9", "ea kept", int'(ea), 16'hC0DE);
    @(negedge clk);
    chk("R9", "start on done later", int'(done), 0);
  endtask

  task automatic t_capture();
    // issue() inverts every context input after start; results must follow the sampled values
    run("R10", 3, 8'h81, 16'h0B00, 0, 8'h01, 8'h02, 0);
    run("R10", 4, 8'h00, 16'h0C00, 1, 8'h10, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_abs();
    t_idx0();
    t_idx8();
    t_idx16();
    t_branch();
    t_gaps();
    t_collide();
    t_capture();
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule